// File: doc/BRIEF.md
# Instruction Cache Line Refill Controller with Early Restart

This block runs the refill of one instruction-cache line after a fetch miss. The fetch pipeline can resume before the whole line has arrived. A miss request carries the line address and the offset of the word that missed. The controller then issues one burst read to a plain memory port. Each returned word goes both to the cache's line storage write port and to a small local copy of the line. The fetch stage is told, cycle by cycle, whether the word it currently asks for is already present. That word's data is supplied from the local copy.

A static parameter selects the burst order. In sequential order the burst always starts at word 0. In wrapped order the burst opens with the missed word, runs up to the last word of the line, wraps to word 0 and stops once every word has been delivered.

Fetch is held until the missed word is present. After that, any word of the line that has already arrived can be fetched with no stall. If fetch leaves the line while the refill is running, streaming ends and fetch stays stalled until the refill has closed. A data-cache miss must wait while a refill runs, and so must a second instruction miss. The line's tag is written once, after the final word.

Top module: `irefill_ctrl`

## Requirements
- R1: `miss_ready` is high exactly when no refill is running. A miss is taken on a cycle where `miss_valid` and `miss_ready` are both high. A miss presented during a refill stays pending, with `miss_ready` low, until the refill has closed.
- R2: With `WRAP_FILL=0`, the burst request address is `{line, 3'd0}` and the words are written in the order 0, 1, ..., 7.
- R3: With `WRAP_FILL=1`, the burst request address is `{line, missed word}`. The words are written in the order m, m+1, ..., 7, 0, ..., m-1, where m is the missed word.
- R4: Every word returned with `mem_rvalid` high during the refill is presented on the write port in the same cycle, with its word index and data. The bench's memory returns `{line, word} ^ 32'hC3A50F00` for each word.
- R5: While a refill runs, `fetch_stall` is high until the missed word has been returned. `fetch_hit` rises in the cycle after that word's beat.
- R6: While a refill runs and no stop is in force, a fetch in the line to any word already returned gives `fetch_hit` high, `fetch_stall` low and that word's data on `fetch_data`. A fetch to a word not yet returned gives `fetch_stall` high.
- R7: If `fetch_in_line` is low with `fetch_valid` high during a refill, `fetch_stall` is high in that cycle. It then stays high, whatever fetch asks for, until the refill has closed.
- R8: `tag_we` is high for exactly one cycle per refill, in the cycle after the last word's beat, with the refilled line on `tag_line`.
- R9: `dmiss_grant` is high only when no refill is running and no instruction miss is being presented. In that state it follows `dmiss_valid`.
- R10: Under reset the block is idle: `miss_ready` is high, and `mem_req_valid`, `fetch_stall`, `tag_we` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| miss_valid | input | 1 | Instruction miss request |
| miss_line | input | LINE_W | Line address of the miss |
| miss_word | input | log2(WORDS) | Word offset that missed |
| miss_ready | output | 1 | Controller idle, miss accepted |
| mem_req_valid | output | 1 | Burst read request |
| mem_req_addr | output | LINE_W+log2(WORDS) | Word address of the first beat |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Returned word strobe |
| mem_rdata | input | DATA_W | Returned word |
| wr_en | output | 1 | Line storage write enable |
| wr_word | output | log2(WORDS) | Word index being written |
| wr_data | output | DATA_W | Word being written |
| tag_we | output | 1 | Tag and valid write, one cycle |
| tag_line | output | LINE_W | Line address for the tag write |
| fetch_valid | input | 1 | Fetch stage is asking for a word |
| fetch_word | input | log2(WORDS) | Word asked for by fetch |
| fetch_in_line | input | 1 | Fetch address lies in the refilling line |
| fetch_hit | output | 1 | Requested word is present |
| fetch_stall | output | 1 | Fetch must wait |
| fetch_data | output | DATA_W | Data of the requested word |
| dmiss_valid | input | 1 | Data-cache miss wants service |
| dmiss_grant | output | 1 | Data-cache miss may proceed |

## Verification
The bench builds two copies side by side from the same stimulus, one with `WRAP_FILL=1` and one with `WRAP_FILL=0`, both with `WORDS=8`, `DATA_W=32` and `LINE_W=27`. Because the two copies deliver the same missed word at very different beats, a single fetch pattern tests both the early-arrival case and the late-arrival case. A miss on word 7 exercises the wrap from the last word to word 0. A miss on word 0 makes the two orders coincide. The memory model answers after three cycles and leaves a one-cycle bubble after the fourth beat, so the streaming checks also cover a stretch where no new word arrives.

// File: rtl/irefill_pkg.sv
package irefill_pkg;

    typedef enum logic [1:0] {
        RF_IDLE  = 2'd0,
        RF_REQ   = 2'd1,
        RF_FILL  = 2'd2,
        RF_CLOSE = 2'd3
    } rf_state_e;

endpackage

// File: rtl/irefill_order.sv
module irefill_order #(
    parameter int WORDS     = 8,
    parameter bit WRAP_FILL = 1'b1,
    localparam int OFS_W    = $clog2(WORDS)
) (
    input  logic [OFS_W-1:0] miss_word,
    input  logic [OFS_W-1:0] beat,
    output logic [OFS_W-1:0] start_word,
    output logic [OFS_W-1:0] beat_word
);

    generate
        if (WRAP_FILL) begin : g_wrap
            assign start_word = miss_word;
            assign beat_word  = OFS_W'((int'(miss_word) + int'(beat)) % WORDS);
        end else begin : g_seq
            logic unused_miss;
            assign unused_miss = ^miss_word;
            assign start_word  = '0;
            assign beat_word   = beat;
        end
    endgenerate

endmodule

// File: rtl/irefill_linebuf.sv
module irefill_linebuf #(
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    localparam int OFS_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFS_W-1:0]  rd_word,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              all_valid
);

    logic [WORDS-1:0]  vld_d, vld_q;
    logic [DATA_W-1:0] data_q [WORDS];

    always_comb begin
        vld_d = vld_q;
        if (clear) begin
            vld_d = '0;
        end else if (wr_en) begin
            vld_d[wr_word] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q <= vld_d;
        end
    end

    generate
        for (genvar i = 0; i < WORDS; i++) begin : g_word
            always_ff @(posedge clk) begin
                if (wr_en && wr_word == OFS_W'(i)) begin
                    data_q[i] <= wr_data;
                end
            end
        end
    endgenerate

    assign rd_data   = data_q[rd_word];
    assign rd_valid  = vld_q[rd_word];
    assign all_valid = &vld_q;

    // R4
    wr_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear) |=> vld_q[$past(wr_word)]);

endmodule

// File: rtl/irefill_ctrl.sv
module irefill_ctrl
    import irefill_pkg::*;
#(
    parameter int LINE_W    = 27,
    parameter int WORDS     = 8,
    parameter int DATA_W    = 32,
    parameter bit WRAP_FILL = 1'b1,
    localparam int OFS_W    = $clog2(WORDS),
    localparam int ADDR_W   = LINE_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [LINE_W-1:0] miss_line,
    input  logic [OFS_W-1:0]  miss_word,
    output logic              miss_ready,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              wr_en,
    output logic [OFS_W-1:0]  wr_word,
    output logic [DATA_W-1:0] wr_data,
    output logic              tag_we,
    output logic [LINE_W-1:0] tag_line,
    input  logic              fetch_valid,
    input  logic [OFS_W-1:0]  fetch_word,
    input  logic              fetch_in_line,
    output logic              fetch_hit,
    output logic              fetch_stall,
    output logic [DATA_W-1:0] fetch_data,
    input  logic              dmiss_valid,
    output logic              dmiss_grant
);

    localparam logic [OFS_W-1:0] LAST_BEAT = OFS_W'(WORDS - 1);

    typedef struct packed {
        rf_state_e         state;
        logic [LINE_W-1:0] line;
        logic [OFS_W-1:0]  req_word;
        logic [OFS_W-1:0]  beat;
        logic              stop;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             busy;
    logic             buf_clear;
    logic             buf_rd_valid;
    logic             buf_all_valid;
    logic [OFS_W-1:0] start_word;
    logic [OFS_W-1:0] beat_word;

    irefill_order #(
        .WORDS     (WORDS),
        .WRAP_FILL (WRAP_FILL)
    ) order_i (
        .miss_word  (ctl_q.req_word),
        .beat       (ctl_q.beat),
        .start_word (start_word),
        .beat_word  (beat_word)
    );

    irefill_linebuf #(
        .WORDS  (WORDS),
        .DATA_W (DATA_W)
    ) linebuf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (buf_clear),
        .wr_en     (wr_en),
        .wr_word   (wr_word),
        .wr_data   (wr_data),
        .rd_word   (fetch_word),
        .rd_data   (fetch_data),
        .rd_valid  (buf_rd_valid),
        .all_valid (buf_all_valid)
    );

    always_comb begin
        ctl_d = ctl_q;
        busy  = (ctl_q.state != RF_IDLE);

        miss_ready    = !busy;
        buf_clear     = !busy && miss_valid;
        mem_req_valid = (ctl_q.state == RF_REQ);
        mem_req_addr  = {ctl_q.line, start_word};
        wr_en         = (ctl_q.state == RF_FILL) && mem_rvalid;
        wr_word       = beat_word;
        wr_data       = mem_rdata;
        tag_we        = (ctl_q.state == RF_CLOSE);
        tag_line      = ctl_q.line;
        dmiss_grant   = dmiss_valid && !busy && !miss_valid;
        fetch_hit     = busy && fetch_valid && fetch_in_line && !ctl_q.stop && buf_rd_valid;
        fetch_stall   = busy && !fetch_hit;

        unique case (ctl_q.state)
            RF_IDLE: begin
                if (miss_valid) begin
                    ctl_d.state    = RF_REQ;
                    ctl_d.line     = miss_line;
                    ctl_d.req_word = miss_word;
                    ctl_d.beat     = '0;
                    ctl_d.stop     = 1'b0;
                end
            end
            RF_REQ: begin
                if (mem_req_ready) begin
                    ctl_d.state = RF_FILL;
                    ctl_d.beat  = '0;
                end
            end
            RF_FILL: begin
                if (mem_rvalid) begin
                    ctl_d.beat = ctl_q.beat + 1'b1;
                    if (ctl_q.beat == LAST_BEAT) begin
                        ctl_d.state = RF_CLOSE;
                    end
                end
            end
            RF_CLOSE: begin
                ctl_d.state = RF_IDLE;
            end
            default: begin
                ctl_d.state = RF_IDLE;
            end
        endcase

        if (busy && fetch_valid && !fetch_in_line) begin
            ctl_d.stop = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: RF_IDLE, line: '0, req_word: '0, beat: '0, stop: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // R1
    held_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_ready |=> tag_line == $past(tag_line));

    // R2, R3
    first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ctl_q.beat == '0) |-> (wr_word == (WRAP_FILL ? ctl_q.req_word : '0)));

    // R5
    req_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fetch_valid && fetch_in_line && fetch_word == ctl_q.req_word && !buf_rd_valid)
        |-> fetch_stall);

    // R7
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy && fetch_valid && !fetch_in_line)) |-> fetch_stall);

    // R8
    tag_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tag_we |-> buf_all_valid);

    // R9
    dgrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmiss_grant |-> !(mem_req_valid || wr_en || tag_we));

endmodule

// File: tb/irefill_ctrl_tb_top.sv
`timescale 1ns/1ps

module irefill_lane #(
    parameter bit WRAP = 1'b1,
    parameter int LAT  = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        miss_valid,
    input  logic [26:0] miss_line,
    input  logic [2:0]  miss_word,
    input  logic        fetch_valid,
    input  logic [2:0]  fetch_word,
    input  logic        fetch_in_line,
    input  logic        dmiss_valid,
    input  logic        miss_ready,
    input  logic        mem_req_valid,
    input  logic [29:0] mem_req_addr,
    input  logic        wr_en,
    input  logic [2:0]  wr_word,
    input  logic [31:0] wr_data,
    input  logic        fetch_stall,
    input  logic        fetch_hit,
    input  logic [31:0] fetch_data,
    input  logic        tag_we,
    input  logic [26:0] tag_line,
    input  logic        dmiss_grant,
    output logic        mem_req_ready,
    output logic        mem_rvalid,
    output logic [31:0] mem_rdata,
    output int          n_chk,
    output int          n_err
);

    function automatic logic [31:0] mdata(input logic [26:0] l, input logic [2:0] w);
        return {2'b00, l, w} ^ 32'hC3A5_0F00;
    endfunction

    logic        m_busy, gap_pend;
    int          m_wait, m_beat;
    logic [26:0] m_line;
    logic [2:0]  m_start, rw;
    logic        lbusy, stop_b, expect_tag;
    logic [7:0]  got;
    int          nrecv;
    logic [26:0] cur_line;
    logic [2:0]  cur_req;
    logic [2:0]  exp_q [$];
    int          c = 0;
    int          e = 0;

    assign mem_req_ready = !m_busy;
    assign n_chk = c;
    assign n_err = e;

    // memory model and expectation driver
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 1'b0; gap_pend <= 1'b0; m_wait <= 0; m_beat <= 0;
            mem_rvalid <= 1'b0; mem_rdata <= '0; rw <= '0;
            lbusy <= 1'b0; stop_b <= 1'b0; expect_tag <= 1'b0; got <= '0; nrecv <= 0;
            cur_line <= '0; cur_req <= '0;
        end else begin
            mem_rvalid <= 1'b0;
            if (!m_busy) begin
                if (mem_req_valid) begin
                    m_busy <= 1'b1; m_wait <= LAT; m_beat <= 0; gap_pend <= 1'b0;
                    m_line <= mem_req_addr[29:3]; m_start <= mem_req_addr[2:0];
                end
            end else if (m_wait != 0) begin
                m_wait <= m_wait - 1;
            end else if (gap_pend) begin
                gap_pend <= 1'b0;
            end else begin
                mem_rvalid <= 1'b1;
                rw         <= 3'(m_start + 3'(m_beat));
                mem_rdata  <= mdata(m_line, 3'(m_start + 3'(m_beat)));
                m_beat     <= m_beat + 1;
                gap_pend   <= (m_beat == 3);
                if (m_beat == 7) m_busy <= 1'b0;
            end

            expect_tag <= mem_rvalid && (nrecv == 7);
            if (miss_valid && !lbusy) begin
                lbusy <= 1'b1; cur_line <= miss_line; cur_req <= miss_word;
                got <= '0; stop_b <= 1'b0; nrecv <= 0;
                for (int k = 0; k < 8; k++) begin
                    exp_q.push_back(WRAP ? 3'(miss_word + 3'(k)) : 3'(k));
                end
            end else begin
                if (mem_rvalid) begin
                    got[rw] <= 1'b1;
                    nrecv   <= nrecv + 1;
                end
                if (lbusy && fetch_valid && !fetch_in_line) stop_b <= 1'b1;
                if (expect_tag) lbusy <= 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        c++;
        if (!ok) begin
            e++;
            $display("FAIL %s %s (wrap=%0d) actual=%0h expected=%0h at %0t", req, what, WRAP, act, exp, $time);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            chk(miss_ready == !lbusy, "R1", "miss_ready", int'(miss_ready), int'(!lbusy));
            if (mem_req_valid && mem_req_ready) begin
                chk(mem_req_addr == {cur_line, (WRAP ? cur_req : 3'd0)}, WRAP ? "R3" : "R2",
                    "burst address", int'(mem_req_addr), int'({cur_line, (WRAP ? cur_req : 3'd0)}));
            end
            if (wr_en) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4", "unexpected write", 1, 0);
                end else begin
                    automatic logic [2:0] w = exp_q.pop_front();
                    chk(wr_word == w, WRAP ? "R3" : "R2", "write order", int'(wr_word), int'(w));
                    chk(wr_data == mdata(cur_line, w), "R4", "write data", int'(wr_data), int'(mdata(cur_line, w)));
                end
            end
            if (lbusy) begin
                automatic bit eh = fetch_valid && fetch_in_line && !stop_b && got[fetch_word];
                automatic string rq = (stop_b || !fetch_in_line) ? "R7" :
                                      ((fetch_word == cur_req) ? "R5" : "R6");
                chk(fetch_hit == eh, rq, "fetch_hit", int'(fetch_hit), int'(eh));
                chk(fetch_stall == !eh, rq, "fetch_stall", int'(fetch_stall), int'(!eh));
                if (eh) begin
                    chk(fetch_data == mdata(cur_line, fetch_word), "R6", "fetch_data",
                        int'(fetch_data), int'(mdata(cur_line, fetch_word)));
                end
            end
            if (tag_we || expect_tag) begin
                chk(tag_we == expect_tag, "R8", "tag_we", int'(tag_we), int'(expect_tag));
                chk(tag_line == cur_line, "R8", "tag_line", int'(tag_line), int'(cur_line));
            end
            if (dmiss_valid) begin
                chk(dmiss_grant == (!lbusy && !miss_valid), "R9", "dmiss_grant",
                    int'(dmiss_grant), int'(!lbusy && !miss_valid));
            end
        end
    end

endmodule

module irefill_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_valid = 1'b0;
    logic [26:0] miss_line = '0;
    logic [2:0]  miss_word = '0;
    logic        fetch_valid = 1'b1;
    logic [2:0]  fetch_word = '0;
    logic        fetch_in_line = 1'b1;
    logic        dmiss_valid = 1'b0;

    always #4 clk = ~clk;

    logic        ready_w, rqv_w, rqr_w, rv_w, wr_w, tag_w, hit_w, stall_w, gnt_w;
    logic [29:0] addr_w;
    logic [31:0] rd_w, wd_w, fd_w;
    logic [2:0]  ww_w;
    logic [26:0] tl_w;
    logic        ready_s, rqv_s, rqr_s, rv_s, wr_s, tag_s, hit_s, stall_s, gnt_s;
    logic [29:0] addr_s;
    logic [31:0] rd_s, wd_s, fd_s;
    logic [2:0]  ww_s;
    logic [26:0] tl_s;
    int          cw, ew, cs, es;
    int          tc = 0;
    int          te = 0;
    bit          done = 1'b0;

    irefill_ctrl #(.LINE_W(27), .WORDS(8), .DATA_W(32), .WRAP_FILL(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_line(miss_line),
        .miss_word(miss_word), .miss_ready(ready_w), .mem_req_valid(rqv_w),
        .mem_req_addr(addr_w), .mem_req_ready(rqr_w), .mem_rvalid(rv_w), .mem_rdata(rd_w),
        .wr_en(wr_w), .wr_word(ww_w), .wr_data(wd_w), .tag_we(tag_w), .tag_line(tl_w),
        .fetch_valid(fetch_valid), .fetch_word(fetch_word), .fetch_in_line(fetch_in_line),
        .fetch_hit(hit_w), .fetch_stall(stall_w), .fetch_data(fd_w),
        .dmiss_valid(dmiss_valid), .dmiss_grant(gnt_w));

    irefill_ctrl #(.LINE_W(27), .WORDS(8), .DATA_W(32), .WRAP_FILL(1'b0)) dut_s (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_line(miss_line),
        .miss_word(miss_word), .miss_ready(ready_s), .mem_req_valid(rqv_s),
        .mem_req_addr(addr_s), .mem_req_ready(rqr_s), .mem_rvalid(rv_s), .mem_rdata(rd_s),
        .wr_en(wr_s), .wr_word(ww_s), .wr_data(wd_s), .tag_we(tag_s), .tag_line(tl_s),
        .fetch_valid(fetch_valid), .fetch_word(fetch_word), .fetch_in_line(fetch_in_line),
        .fetch_hit(hit_s), .fetch_stall(stall_s), .fetch_data(fd_s),
        .dmiss_valid(dmiss_valid), .dmiss_grant(gnt_s));

    irefill_lane #(.WRAP(1'b1)) lane_w (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_line(miss_line),
        .miss_word(miss_word), .fetch_valid(fetch_valid), .fetch_word(fetch_word),
        .fetch_in_line(fetch_in_line), .dmiss_valid(dmiss_valid), .miss_ready(ready_w),
        .mem_req_valid(rqv_w), .mem_req_addr(addr_w), .wr_en(wr_w), .wr_word(ww_w),
        .wr_data(wd_w), .fetch_stall(stall_w), .fetch_hit(hit_w), .fetch_data(fd_w),
        .tag_we(tag_w), .tag_line(tl_w), .dmiss_grant(gnt_w), .mem_req_ready(rqr_w),
        .mem_rvalid(rv_w), .mem_rdata(rd_w), .n_chk(cw), .n_err(ew));

    irefill_lane #(.WRAP(1'b0)) lane_s (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_line(miss_line),
        .miss_word(miss_word), .fetch_valid(fetch_valid), .fetch_word(fetch_word),
        .fetch_in_line(fetch_in_line), .dmiss_valid(dmiss_valid), .miss_ready(ready_s),
        .mem_req_valid(rqv_s), .mem_req_addr(addr_s), .wr_en(wr_s), .wr_word(ww_s),
        .wr_data(wd_s), .fetch_stall(stall_s), .fetch_hit(hit_s), .fetch_data(fd_s),
        .tag_we(tag_s), .tag_line(tl_s), .dmiss_grant(gnt_s), .mem_req_ready(rqr_s),
        .mem_rvalid(rv_s), .mem_rdata(rd_s), .n_chk(cs), .n_err(es));

    task automatic tchk(input bit ok, input string what, input int act, input int exp);
        tc++;
        if (!ok) begin
            te++;
            $display("FAIL R10 %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic do_miss(input logic [26:0] l, input logic [2:0] w);
        miss_line  = l;
        miss_word  = w;
        miss_valid = 1'b1;
        do @(negedge clk); while (!ready_w);
        @(posedge clk);
        #1 miss_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!ready_w);
        cyc();
        cyc();
    endtask

    task automatic idle_state();
        tchk(ready_w && ready_s, "miss_ready", int'({ready_w, ready_s}), 3);
        tchk(!rqv_w && !rqv_s, "mem_req_valid", int'({rqv_w, rqv_s}), 0);
        tchk(!stall_w && !stall_s, "fetch_stall", int'({stall_w, stall_s}), 0);
        tchk(!tag_w && !tag_s, "tag_we", int'({tag_w, tag_s}), 0);
        tchk(!wr_w && !wr_s, "wr_en", int'({wr_w, wr_s}), 0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", te + ew + es, tc + cw + cs);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            te++;
            tc++;
            $display("FAIL watchdog: run did not end");
            summary();
            $finish;
        end
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        idle_state();
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        idle_state();
        cyc();

        // R5 R6: miss on word 5, fetch waits on it then walks forward
        fetch_word = 3'd5;
        do_miss(27'h0000123, 3'd5);
        repeat (12) cyc();
        fetch_word = 3'd6;
        repeat (3) cyc();
        fetch_word = 3'd7;
        wait_idle();

        // R7 R1 R9: branch away, data miss and second miss during refill
        fetch_word = 3'd2;
        do_miss(27'h0000456, 3'd2);
        repeat (6) cyc();
        fetch_in_line = 1'b0;
        cyc();
        fetch_in_line = 1'b1;
        fetch_word    = 3'd3;
        dmiss_valid   = 1'b1;
        do_miss(27'h0000789, 3'd7);
        dmiss_valid = 1'b0;
        fetch_word  = 3'd7;
        repeat (10) cyc();
        fetch_word  = 3'd0;
        wait_idle();

        // R9: data miss alone while idle
        dmiss_valid = 1'b1;
        repeat (2) cyc();
        dmiss_valid = 1'b0;
        cyc();

        // R2 R3 R6: miss on word 0, fetch idle a while then steps across the line
        fetch_valid = 1'b0;
        fetch_word  = 3'd0;
        do_miss(27'h7FFFFFF, 3'd0);
        repeat (3) cyc();
        fetch_valid = 1'b1;
        for (int k = 0; k < 8; k++) begin
            fetch_word = 3'(k);
            repeat (2) cyc();
        end
        wait_idle();

        @(negedge clk);
        idle_state();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule